// File: doc/BRIEF.md
# Floating-Point Coprocessor Issue Controller

This block steers instructions through a small floating-point coprocessor that has four execution pipes of different fixed lengths: an arithmetic/logic pipe, a multiplier pipe, a non-pipelined divider and a load pipe. The host offers one instruction at a time, in program order, through a valid/ready handshake. Once accepted, instructions run in parallel and may finish out of order. Each finishing instruction either writes its destination register or, when its operands were flagged as exception-prone, reports an exception.

Dependencies are tracked with a single busy bit per architectural register, with no central table. A register's bit is set when an instruction that writes it is accepted and cleared when that instruction leaves. When several pipes finish in the same cycle, one shared write port serves the oldest instruction first.

A hint bit travels with each instruction. The first execute stage of the pipe turns that hint into an exception prediction. A predicted instruction stops all further issue and waits until every older instruction has left. Only then does it report, which keeps the exception precise. The arithmetic itself is modelled as latency only.

Top module: `fpcop_issue_ctrl`

## Requirements
- R1: After reset, no register is busy, `instReady` is 1 for any offered instruction, `wbValid` is 0 and `excFlag` is 0.
- R2: Opcodes 0 (add), 1 (subtract), 2 (convert), 3 (compare) and 4 (round) go to the arithmetic pipe. Opcode 5 goes to the multiplier, opcode 6 to the divider and opcode 7 (load) to the load pipe. `wbPipe` reports 0, 1, 2 and 3 for these pipes, in that order. With no conflict, `wbValid` rises exactly 2, 3, 8 or 1 cycles after the accept cycle (defaults `LAT_ALU`, `LAT_MUL`, `LAT_DIV`, `LAT_LD`).
- R3: An instruction is not accepted while its source A, source B or destination register is busy. The busy bit of the destination is set on accept and cleared at the edge that ends its write-back cycle. A stalled dependent instruction is therefore accepted in the cycle after the write-back.
- R4: A younger instruction in a shorter pipe writes back before an older instruction in a longer pipe.
- R5: The divider takes a new instruction only when it is empty. A second divide is accepted one cycle after the first one's write-back cycle.
- R6: The multiplier and arithmetic pipes accept a new instruction every cycle.
- R7: When two pipes finish in the same cycle, the instruction accepted earlier wins the write port. The other pipe holds its result and writes back in the following cycle.
- R8: A non-load instruction offered with `instHint` = 1 never writes its register. While it is in a pipe, no instruction is accepted. It reports only after every older instruction has left. `excFlag` rises in the cycle after its report, and `excOp` holds its opcode.
- R9: `instHint` has no effect on a load. The load writes back at its normal latency and `excFlag` stays 0.
- R10: `excFlag` stays 1 until `excAck` is pulsed. Issue resumes after the report without waiting for the acknowledge.
- R11: The report of a predicted exception clears the busy bit of that instruction's destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Host offers an instruction |
| instOp | input | 3 | Opcode (encoding in R2) |
| instDst | input | 5 | Destination register |
| instSrcA | input | 5 | First source register |
| instSrcB | input | 5 | Second source register |
| instHint | input | 1 | Operands flagged as exception-prone |
| excAck | input | 1 | Clears the sticky exception flag |
| instReady | output | 1 | Instruction accepted when high together with instValid |
| wbValid | output | 1 | Register write-back this cycle |
| wbReg | output | 5 | Register written |
| wbPipe | output | 2 | Pipe that produced the write |
| excFlag | output | 1 | Sticky exception flag |
| excOp | output | 3 | Opcode of the last reported exception |

## Verification
The assertions rely on a few properties of the input. The host holds at most as many instructions in flight as the pipes can carry, so issue tags never wrap past half their range. The host never acknowledges an exception in the same cycle as a new report. Sources and destination are registers that the host names deliberately, even for a load. The directed tasks keep to these conditions: they use distinct registers per scenario, they let the pipes drain between scenarios, and they pulse `excAck` only well after the report, so every expected cycle follows from the latencies alone.

// File: rtl/fpcop_pkg.sv
package fpcop_pkg;
  parameter int REG_W  = 5;
  parameter int TAG_W  = 4;
  parameter int OP_W   = 3;
  parameter int NPIPE  = 4;
  parameter int PIPE_W = 2;
  localparam int NREG  = 1 << REG_W;

  localparam logic [OP_W-1:0] OP_MUL  = OP_W'(5);
  localparam logic [OP_W-1:0] OP_DIV  = OP_W'(6);
  localparam logic [OP_W-1:0] OP_LOAD = OP_W'(7);

  typedef struct packed {
    logic              trap;
    logic [OP_W-1:0]   op;
    logic [REG_W-1:0]  dst;
    logic [TAG_W-1:0]  tag;
  } entry_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              go;
    logic [NPIPE-1:0]  sel;
    logic              hint;
    logic [OP_W-1:0]   op;
    logic [REG_W-1:0]  dst;
    logic [TAG_W-1:0]  tag;
  } issue_t;

  // datapath -> control status
  typedef struct packed {
    logic [NPIPE-1:0]  free;
    logic              trapBusy;
    logic              wbValid;
    logic              excValid;
    logic [REG_W-1:0]  dst;
    logic [OP_W-1:0]   op;
    logic [PIPE_W-1:0] pipe;
  } status_t;

  function automatic logic [NPIPE-1:0] pipeOf(input logic [OP_W-1:0] op);
    case (op)
      OP_MUL:  pipeOf = NPIPE'(2);
      OP_DIV:  pipeOf = NPIPE'(4);
      OP_LOAD: pipeOf = NPIPE'(8);
      default: pipeOf = NPIPE'(1);
    endcase
  endfunction

  function automatic logic isOlder(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    isOlder = d[TAG_W-1];
  endfunction
endpackage

// File: rtl/fpcop_pipe.sv
module fpcop_pipe
  import fpcop_pkg::*;
#(
  parameter int LAT   = 2,
  parameter bit PIPED = 1'b1,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inGo,
  input  logic [TAG_W-1:0] inTag,
  input  logic [REG_W-1:0] inDst,
  input  logic [OP_W-1:0]  inOp,
  input  logic             inHint,
  input  logic             alone,
  input  logic             grant,
  output logic             canAccept,
  output logic             req,
  output logic             trapAny,
  output logic [CNT_W-1:0] occ,
  output entry_t           lastEnt
);
  logic [LAT-1:0] stV;
  logic [LAT-1:0] trapV;
  entry_t         stE [LAT];
  logic           advance;

  always_comb begin
    advance = !(stV[LAT-1] && !grant);
    lastEnt = stE[LAT-1];
    occ     = CNT_W'($countones(stV));
    for (int i = 0; i < LAT; i++) trapV[i] = stV[i] && stE[i].trap;
    trapAny = |trapV;
    // a predicted exception leaves only when it is the last thing in flight
    req       = stV[LAT-1] && (!stE[LAT-1].trap || alone);
    canAccept = PIPED ? advance : (stV == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stV <= '0;
      for (int i = 0; i < LAT; i++) stE[i] <= '0;
    end else if (advance) begin
      stV[0] <= inGo;
      // first execute stage: operand-based exception prediction
      stE[0] <= '{trap: inHint && (inOp != OP_LOAD), op: inOp, dst: inDst, tag: inTag};
      for (int i = 1; i < LAT; i++) begin
        stV[i] <= stV[i-1];
        stE[i] <= stE[i-1];
      end
    end
  end

  // R5 / R6: control only pushes when this pipe can take it
  a_r5_push_when_free: assert property (@(posedge clk) disable iff (!rstN)
    inGo |-> canAccept);
  // R7: a result that lost the port is held unchanged
  a_r7_loser_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stV[LAT-1] && !grant) |=> (stV[LAT-1] && $stable(lastEnt)));
endmodule

// File: rtl/fpcop_exec_dp.sv
module fpcop_exec_dp
  import fpcop_pkg::*;
#(
  parameter int LAT_ALU = 2,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 8,
  parameter int LAT_LD  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  issue_t  iss,
  output status_t st
);
  localparam int CNT_W = $clog2(LAT_ALU + LAT_MUL + LAT_DIV + LAT_LD + 1);

  logic [NPIPE-1:0] req, grant, trapVec, freeVec;
  logic [CNT_W-1:0] occ [NPIPE];
  entry_t           lastEnt [NPIPE];
  logic [CNT_W-1:0] totalOcc;
  logic             alone;

  for (genvar g = 0; g < NPIPE; g++) begin : gPipe
    localparam int L = (g == 0) ? LAT_ALU : (g == 1) ? LAT_MUL : (g == 2) ? LAT_DIV : LAT_LD;
    fpcop_pipe #(.LAT(L), .PIPED(g != 2), .CNT_W(CNT_W)) uPipe (
      .clk       (clk),
      .rstN      (rstN),
      .inGo      (iss.go && iss.sel[g]),
      .inTag     (iss.tag),
      .inDst     (iss.dst),
      .inOp      (iss.op),
      .inHint    (iss.hint),
      .alone     (alone),
      .grant     (grant[g]),
      .canAccept (freeVec[g]),
      .req       (req[g]),
      .trapAny   (trapVec[g]),
      .occ       (occ[g]),
      .lastEnt   (lastEnt[g])
    );
  end

  always_comb begin
    totalOcc = '0;
    for (int i = 0; i < NPIPE; i++) totalOcc = totalOcc + occ[i];
    alone = (totalOcc == CNT_W'(1));
  end

  // write-port arbitration: oldest requester wins
  always_comb begin
    for (int i = 0; i < NPIPE; i++) begin
      grant[i] = req[i];
      for (int j = 0; j < NPIPE; j++)
        if (j != i && req[j] && !isOlder(lastEnt[i].tag, lastEnt[j].tag)) grant[i] = 1'b0;
    end
  end

  always_comb begin
    st          = '0;
    st.free     = freeVec;
    st.trapBusy = |trapVec;
    for (int i = 0; i < NPIPE; i++) begin
      if (grant[i]) begin
        st.wbValid  = !lastEnt[i].trap;
        st.excValid = lastEnt[i].trap;
        st.dst      = lastEnt[i].dst;
        st.op       = lastEnt[i].op;
        st.pipe     = PIPE_W'(i);
      end
    end
  end

  // R7: one owner of the write port per cycle
  a_r7_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  // R8: no issue while a predicted exception is in flight
  a_r8_issue_blocked: assert property (@(posedge clk) disable iff (!rstN)
    st.trapBusy |-> !iss.go);
endmodule

// File: rtl/fpcop_issue_ctl.sv
module fpcop_issue_ctl
  import fpcop_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [OP_W-1:0]  instOp,
  input  logic [REG_W-1:0] instDst,
  input  logic [REG_W-1:0] instSrcA,
  input  logic [REG_W-1:0] instSrcB,
  input  logic             instHint,
  input  logic             excAck,
  input  status_t          st,
  output issue_t           iss,
  output logic             instReady,
  output logic             excFlag,
  output logic [OP_W-1:0]  excOp
);
  logic [NREG-1:0]  pending, setMask, clrMask;
  logic [TAG_W-1:0] seq;
  logic [NPIPE-1:0] sel;
  logic             hazard;

  always_comb begin
    sel       = pipeOf(instOp);
    hazard    = pending[instSrcA] | pending[instSrcB] | pending[instDst];
    instReady = !hazard && |(sel & st.free) && !st.trapBusy;
    iss.go    = instValid && instReady;
    iss.sel   = sel;
    iss.hint  = instHint;
    iss.op    = instOp;
    iss.dst   = instDst;
    iss.tag   = seq;
    setMask   = iss.go ? (NREG'(1) << instDst) : '0;
    clrMask   = (st.wbValid || st.excValid) ? (NREG'(1) << st.dst) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      seq     <= '0;
      excFlag <= 1'b0;
      excOp   <= '0;
    end else begin
      pending <= (pending & ~clrMask) | setMask;
      if (iss.go) seq <= seq + TAG_W'(1);
      if (st.excValid) begin
        excFlag <= 1'b1;
        excOp   <= st.op;
      end else if (excAck) begin
        excFlag <= 1'b0;
      end
    end
  end

  // R3 / R11: anything leaving a pipe frees a register that was busy
  a_r3_retire_was_busy: assert property (@(posedge clk) disable iff (!rstN)
    (st.wbValid || st.excValid) |-> pending[st.dst]);
  // R8: a report sets the sticky flag
  a_r8_report_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    st.excValid |=> excFlag);
  // R10: flag holds until acknowledged
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (excFlag && !excAck) |=> excFlag);
endmodule

// File: rtl/fpcop_issue_ctrl.sv
module fpcop_issue_ctrl
  import fpcop_pkg::*;
#(
  parameter int LAT_ALU = 2,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 8,
  parameter int LAT_LD  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [OP_W-1:0]   instOp,
  input  logic [REG_W-1:0]  instDst,
  input  logic [REG_W-1:0]  instSrcA,
  input  logic [REG_W-1:0]  instSrcB,
  input  logic              instHint,
  input  logic              excAck,
  output logic              instReady,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbReg,
  output logic [PIPE_W-1:0] wbPipe,
  output logic              excFlag,
  output logic [OP_W-1:0]   excOp
);
  issue_t  iss;
  status_t st;

  fpcop_issue_ctl uCtl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp), .instDst(instDst),
    .instSrcA(instSrcA), .instSrcB(instSrcB), .instHint(instHint), .excAck(excAck),
    .st(st), .iss(iss), .instReady(instReady), .excFlag(excFlag), .excOp(excOp)
  );

  fpcop_exec_dp #(.LAT_ALU(LAT_ALU), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV), .LAT_LD(LAT_LD)) uDp (
    .clk(clk), .rstN(rstN), .iss(iss), .st(st)
  );

  assign wbValid = st.wbValid;
  assign wbReg   = st.dst;
  assign wbPipe  = st.pipe;
endmodule

// File: tb/fpcop_issue_ctrl_bench.sv
`timescale 1ns/1ps
module fpcop_issue_ctrl_bench;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       instValid = 1'b0, instHint = 1'b0, excAck = 1'b0;
  logic [2:0] instOp = '0;
  logic [4:0] instDst = '0, instSrcA = '0, instSrcB = '0;
  logic       instReady, wbValid, excFlag;
  logic [4:0] wbReg;
  logic [1:0] wbPipe;
  logic [2:0] excOp;

  int cyc = 0, errs = 0, checks = 0;
  int wbCyc [32];
  int wbPipeLog [32];
  int wbCnt [32];
  int excRise = -1;
  logic prevExc = 1'b0;

  fpcop_issue_ctrl u_fpcop_issue_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp), .instDst(instDst),
    .instSrcA(instSrcA), .instSrcB(instSrcB), .instHint(instHint), .excAck(excAck),
    .instReady(instReady), .wbValid(wbValid), .wbReg(wbReg), .wbPipe(wbPipe),
    .excFlag(excFlag), .excOp(excOp)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wbValid) begin
      wbCyc[wbReg]     = cyc;
      wbPipeLog[wbReg] = int'(wbPipe);
      wbCnt[wbReg]     = wbCnt[wbReg] + 1;
    end
    if (excFlag && !prevExc) excRise = cyc;
    prevExc = excFlag;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clrLog();
    for (int i = 0; i < 32; i++) begin wbCyc[i] = -1; wbPipeLog[i] = -1; wbCnt[i] = 0; end
  endtask

  task automatic issue(input int op, input int dst, input int a, input int b, input bit hint,
                       output int acc);
    @(negedge clk);
    instValid = 1'b1; instOp = 3'(op); instDst = 5'(dst);
    instSrcA = 5'(a); instSrcB = 5'(b); instHint = hint;
    #1;
    while (!instReady) begin @(negedge clk); #1; end
    acc = cyc;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); instValid = 1'b0; instHint = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); instOp = 3'd0; instDst = 5'd1; instSrcA = 5'd2; instSrcB = 5'd3; #1;
    check(instReady == 1'b1, "R1 ready", int'(instReady), 1);
    check(wbValid == 1'b0, "R1 wbValid", int'(wbValid), 0);
    check(excFlag == 1'b0, "R1 excFlag", int'(excFlag), 0);
  endtask

  task automatic t_latency();
    int a1, a2, a3, a4;
    clrLog();
    issue(1, 1, 20, 21, 0, a1); idle(12);
    issue(5, 2, 20, 21, 0, a2); idle(12);
    issue(6, 3, 20, 21, 0, a3); idle(12);
    issue(7, 4, 20, 21, 0, a4); idle(12);
    check(wbCyc[1] - a1 == 2, "R2 alu latency", wbCyc[1] - a1, 2);
    check(wbPipeLog[1] == 0, "R2 alu pipe", wbPipeLog[1], 0);
    check(wbCyc[2] - a2 == 3, "R2 mul latency", wbCyc[2] - a2, 3);
    check(wbPipeLog[2] == 1, "R2 mul pipe", wbPipeLog[2], 1);
    check(wbCyc[3] - a3 == 8, "R2 div latency", wbCyc[3] - a3, 8);
    check(wbPipeLog[3] == 2, "R2 div pipe", wbPipeLog[3], 2);
    check(wbCyc[4] - a4 == 1, "R2 load latency", wbCyc[4] - a4, 1);
    check(wbPipeLog[4] == 3, "R2 load pipe", wbPipeLog[4], 3);
  endtask

  task automatic t_dependency();
    int a1, a2, b1, b2;
    clrLog();
    issue(5, 5, 20, 21, 0, a1);
    issue(0, 6, 5, 7, 0, a2); idle(8);
    check(a2 == a1 + 4, "R3 source busy stall", a2 - a1, 4);
    check(wbCyc[6] == a2 + 2, "R3 dependent result", wbCyc[6], a2 + 2);
    issue(5, 8, 20, 21, 0, b1);
    issue(7, 8, 20, 21, 0, b2); idle(8);
    check(b2 == b1 + 4, "R3 destination busy stall", b2 - b1, 4);
    check(wbCnt[8] == 2, "R3 both writes", wbCnt[8], 2);
  endtask

  task automatic t_ooo();
    int a1, a2;
    clrLog();
    issue(6, 9, 20, 21, 0, a1);
    issue(0, 10, 20, 21, 0, a2); idle(12);
    check(a2 == a1 + 1, "R4 younger accepted", a2 - a1, 1);
    check(wbCyc[10] == a2 + 2 && wbCyc[9] == a1 + 8, "R4 out-of-order finish",
          wbCyc[10] - wbCyc[9], (a2 + 2) - (a1 + 8));
  endtask

  task automatic t_divider();
    int a1, a2;
    clrLog();
    issue(6, 11, 20, 21, 0, a1);
    issue(6, 12, 20, 21, 0, a2); idle(12);
    check(a2 == a1 + 9, "R5 divider busy", a2 - a1, 9);
  endtask

  task automatic t_pipelined();
    int a1, a2, b1, b2;
    clrLog();
    issue(5, 13, 20, 21, 0, a1);
    issue(5, 14, 20, 21, 0, a2); idle(6);
    check(a2 == a1 + 1, "R6 mul back-to-back", a2 - a1, 1);
    check(wbCyc[14] == a1 + 4, "R6 second mul result", wbCyc[14], a1 + 4);
    issue(2, 23, 20, 21, 0, b1);
    issue(4, 24, 20, 21, 0, b2); idle(6);
    check(b2 == b1 + 1, "R6 alu back-to-back", b2 - b1, 1);
  endtask

  task automatic t_collision();
    int a1, a2, b1, b2;
    clrLog();
    issue(5, 15, 20, 21, 0, a1);
    issue(0, 16, 20, 21, 0, a2); idle(8);
    check(wbCyc[15] == a1 + 3, "R7 older mul wins", wbCyc[15], a1 + 3);
    check(wbCyc[16] == a1 + 4, "R7 alu delayed one cycle", wbCyc[16], a1 + 4);
    issue(3, 17, 20, 21, 0, b1);
    issue(7, 18, 20, 21, 0, b2); idle(8);
    check(wbCyc[17] == b1 + 2, "R7 older alu wins", wbCyc[17], b1 + 2);
    check(wbCyc[18] == b1 + 3, "R7 load delayed one cycle", wbCyc[18], b1 + 3);
  endtask

  task automatic t_exception();
    int a1, a2, a3, a4;
    clrLog();
    issue(6, 19, 25, 26, 0, a1);
    issue(1, 27, 25, 26, 1, a2);
    issue(7, 21, 25, 26, 0, a3);
    check(a3 == a1 + 10, "R8 issue blocked until report", a3 - a1, 10);
    issue(0, 27, 25, 26, 0, a4); idle(6);
    check(a4 == a3 + 1, "R11 destination freed by report", a4 - a3, 1);
    check(excRise == a1 + 10, "R8 report after older divide", excRise, a1 + 10);
    check(wbCyc[19] == a1 + 8, "R8 older divide completes", wbCyc[19], a1 + 8);
    check(excOp == 3'd1, "R8 faulting opcode", int'(excOp), 1);
    check(wbCnt[27] == 1, "R8 no write from faulting op", wbCnt[27], 1);
    check(excFlag == 1'b1, "R10 issue resumed with flag set", int'(excFlag), 1);
  endtask

  task automatic t_sticky();
    idle(10);
    check(excFlag == 1'b1, "R10 flag stays set", int'(excFlag), 1);
    @(negedge clk); excAck = 1'b1;
    @(negedge clk); excAck = 1'b0; #1;
    check(excFlag == 1'b0, "R10 flag cleared by ack", int'(excFlag), 0);
  endtask

  task automatic t_loadHint();
    int a1, r0;
    clrLog();
    r0 = excRise;
    issue(7, 22, 25, 26, 1, a1); idle(6);
    check(wbCyc[22] == a1 + 1, "R9 hinted load writes", wbCyc[22], a1 + 1);
    check(excFlag == 1'b0 && excRise == r0, "R9 hint ignored on load", int'(excFlag), 0);
  endtask

  initial begin
    clrLog();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_latency();
    t_dependency();
    t_ooo();
    t_divider();
    t_pipelined();
    t_collision();
    t_exception();
    t_sticky();
    t_loadHint();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule